// File: doc/BRIEF.md
# Triggered DMA Request Burst Generator

This block is one channel of a DMA request generator. It picks one trigger line out of a bank of up to 32 asynchronous inputs, synchronizes it, and watches it for a programmed edge. Each qualifying edge starts a burst of N+1 DMA requests, where N comes from a count field in the control word. The requests go to a downstream DMA controller over a valid/ready handshake.

A 32-bit control word holds the trigger select, the edge mode, the channel enable, the overrun interrupt enable and the request count. A trigger event that arrives while a burst is still running is dropped. It sets a sticky overrun flag, and the interrupt follows that flag when the interrupt enable is set. A one-cycle clear pulse resets the flag.

Request handshake rules: `req_valid` rises when a burst starts. It stays high, unchanged, until a cycle in which `req_ready` is also high; that cycle transfers one request. After the last transfer of a burst, `req_valid` goes low for at least one cycle. The downstream side may hold `req_ready` low for as long as it needs, and the burst simply stalls. The only way `req_valid` drops without a transfer is a clear of the channel enable.

Top module: `dma_burst_trigger_gen`

## Requirements
- R1: After reset the control word reads as all zeros, and `req_valid`, `ovr_flag` and `irq` are low.
- R2: With edge mode 01 in bits 18:17, a low-to-high transition of the selected trigger starts one burst, and a high-to-low transition starts none.
- R3: With edge mode 10, a high-to-low transition of the selected trigger starts one burst, and a low-to-high transition starts none.
- R4: With edge mode 11, every transition of the selected trigger, in either direction, starts one burst.
- R5: With edge mode 00, no transition of the trigger starts a burst.
- R6: Bits 4:0 of the control word select which `trig_in` line is watched; transitions on any other line start no burst.
- R7: While the enable bit 16 reads 0, `req_valid` is low in every cycle after that one. Clearing the enable during a burst drops `req_valid` in the cycle after the write and abandons the rest of the burst. Triggers seen while disabled start nothing.
- R8: Each burst makes exactly N+1 transfers, where N is bits 23:19. `req_valid` is held high while `req_ready` is low.
- R9: A write that lands while the enable bit reads 1 leaves the count field bits 23:19 unchanged. Later bursts still use the old count.
- R10: A trigger event seen while a burst is in progress sets `ovr_flag` and adds no transfers.
- R11: `irq` is high exactly when `ovr_flag` is high and bit 8 of the control word is 1. A pulse on `ovr_clr` clears `ovr_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Current control word (unused bits read 0) |
| ovr_clr | input | 1 | One-cycle pulse that clears the overrun flag |
| trig_in | input | NUM_TRIG | Asynchronous trigger candidates |
| req_valid | output | 1 | DMA request valid |
| req_ready | input | 1 | DMA request acknowledge (ready) |
| ovr_flag | output | 1 | Sticky overrun flag |
| irq | output | 1 | Overrun interrupt |

## Verification
The bench drives bursts against three kinds of back-pressure, continuous, alternating and fully stalled, and counts transfers per burst against a queue of expected lengths. A counter that is off by one makes a burst one transfer short or long. A `req_valid` that drops without a transfer shows up as a missing transfer or an extra burst. The bench tests every edge mode with both directions of transition, so an inverted polarity decode appears as a burst where none was due, or as no burst where one was. It also checks a count write while enabled, an overrun raised by a re-trigger during a stalled burst, and an abort by disable. If the count write is not ignored, the next burst has the wrong length. If a dropped trigger is queued instead of discarded, an extra burst appears. If the abort is incomplete, requests continue after the disable.

// File: rtl/drg_pkg.sv
package drg_pkg;
  localparam int CTRL_W  = 32;
  localparam int SEL_LSB = 0;
  localparam int SEL_W   = 5;
  localparam int OIE_BIT = 8;
  localparam int EN_BIT  = 16;
  localparam int POL_LSB = 17;
  localparam int CNT_LSB = 19;
  localparam int CNT_W   = 5;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    edge_mode_e       mode;
    logic             en;
    logic             oie;
    logic [SEL_W-1:0] sel;
  } chan_cfg_t;
endpackage

// File: rtl/drg_cfg_reg.sv
module drg_cfg_reg
  import drg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output chan_cfg_t         cfg,
  output logic [CTRL_W-1:0] rdata
);
  chan_cfg_t nxt;

  always_comb begin
    nxt      = cfg;
    nxt.sel  = wdata[SEL_LSB +: SEL_W];
    nxt.oie  = wdata[OIE_BIT];
    nxt.en   = wdata[EN_BIT];
    nxt.mode = edge_mode_e'(wdata[POL_LSB +: 2]);
    // count is frozen while the channel is running
    if (!cfg.en) nxt.cnt = wdata[CNT_LSB +: CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else if (we) cfg <= nxt;
  end

  always_comb begin
    rdata                    = '0;
    rdata[SEL_LSB +: SEL_W]  = cfg.sel;
    rdata[OIE_BIT]           = cfg.oie;
    rdata[EN_BIT]            = cfg.en;
    rdata[POL_LSB +: 2]      = cfg.mode;
    rdata[CNT_LSB +: CNT_W]  = cfg.cnt;
  end
endmodule

// File: rtl/drg_edge_det.sv
module drg_edge_det
  import drg_pkg::*;
#(
  parameter int NUM_TRIG = 32,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]    sel,
  input  edge_mode_e          mode,
  output logic                evt
);
  logic              pick;
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++)
      if (sel == SEL_W'(i)) pick = trig_in[i];
  end

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pick;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pick};
    end
  endgenerate

  assign cur = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;

  always_comb begin
    unique case (mode)
      EDGE_RISE: evt = cur & ~prev_q;
      EDGE_FALL: evt = ~cur & prev_q;
      EDGE_BOTH: evt = cur ^ prev_q;
      default:   evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/drg_burst_ctl.sv
module drg_burst_ctl
  import drg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             oie,
  input  logic [CNT_W-1:0] cnt,
  input  logic             evt,
  input  logic             ovr_clr,
  input  logic             req_ready,
  output logic             req_valid,
  output logic             ovr_flag,
  output logic             irq
);
  logic             busy_q;
  logic [CNT_W-1:0] left_q;
  logic             xfer;

  assign req_valid = busy_q & en;
  assign xfer      = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (!en) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (!busy_q) begin
      if (evt) begin
        busy_q <= 1'b1;
        left_q <= cnt;
      end
    end else if (xfer) begin
      if (left_q == '0) busy_q <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ovr_flag <= 1'b0;
    else if (evt && busy_q && en) ovr_flag <= 1'b1;
    else if (ovr_clr)            ovr_flag <= 1'b0;
  end

  assign irq = ovr_flag & oie;
endmodule

// File: rtl/dma_burst_trigger_gen.sv
module dma_burst_trigger_gen
  import drg_pkg::*;
#(
  parameter int NUM_TRIG    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CTRL_W-1:0]   cfg_wdata,
  output logic [CTRL_W-1:0]   cfg_rdata,
  input  logic                ovr_clr,
  input  logic [NUM_TRIG-1:0] trig_in,
  output logic                req_valid,
  input  logic                req_ready,
  output logic                ovr_flag,
  output logic                irq
);
  chan_cfg_t cfg;
  logic      evt;

  drg_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  drg_edge_det #(.NUM_TRIG(NUM_TRIG), .STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (trig_in),
    .sel     (cfg.sel),
    .mode    (cfg.mode),
    .evt     (evt)
  );

  drg_burst_ctl u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg.en),
    .oie       (cfg.oie),
    .cnt       (cfg.cnt),
    .evt       (evt),
    .ovr_clr   (ovr_clr),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .ovr_flag  (ovr_flag),
    .irq       (irq)
  );
endmodule

// File: rtl/drg_checker.sv
module drg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        req_valid,
  input logic        req_ready,
  input logic        ovr_flag,
  input logic        irq
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !(cfg_we && !cfg_wdata[16]) |=> req_valid); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[16] |=> !req_valid); // R7
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[16] |=> $stable(cfg_rdata[23:19])); // R9
  AST_OVR_NEEDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(req_valid)); // R10
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovr_flag && cfg_rdata[8]); // R11
endmodule

bind dma_burst_trigger_gen drg_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ovr_flag  (ovr_flag),
  .irq       (irq)
);

// File: tb/sim_dma_burst_trigger_gen.sv
module sim_dma_burst_trigger_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ovr_clr = 1'b0;
  logic [31:0] trig_in = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic        ovr_flag;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  int hs_cnt = 0, bursts = 0, cyc = 0, rmode = 0;
  logic prev_v = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_burst_trigger_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ovr_clr(ovr_clr), .trig_in(trig_in),
    .req_valid(req_valid), .req_ready(req_ready), .ovr_flag(ovr_flag), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ready pattern: 0 always, 1 alternate, 2 never
  always @(posedge clk) begin
    cyc <= cyc + 1;
    req_ready <= (rmode == 0) ? 1'b1 : (rmode == 1) ? cyc[0] : 1'b0;
  end

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    if (!prev_v && req_valid) begin bursts++; hs_cnt = 0; end
    if (req_valid && req_ready) hs_cnt++;
    if (prev_v && !req_valid) begin
      if (exp_q.size() == 0) chk(0, "R8 unexpected burst", hs_cnt, -1);
      else begin
        automatic int e = exp_q.pop_front();
        chk(hs_cnt == e, "R8 burst length", hs_cnt, e);
      end
    end
    prev_v = req_valid;
  end

  function automatic logic [31:0] mk(int sel, bit oie, bit en, int mode, int cnt);
    logic [31:0] w = '0;
    w[4:0] = sel[4:0]; w[8] = oie; w[16] = en; w[18:17] = mode[1:0]; w[23:19] = cnt[4:0];
    return w;
  endfunction

  task automatic wr(input logic [31:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic setcfg(int sel, bit oie, int mode, int cnt);
    wr(mk(sel, oie, 0, mode, cnt));
    wr(mk(sel, oie, 1, mode, cnt));
  endtask

  task automatic drive(int line, bit v);
    @(negedge clk); trig_in[line] = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  initial begin
    #4000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_rdata == 0, "R1 ctrl reset", cfg_rdata, 0);
    chk(!req_valid && !ovr_flag && !irq, "R1 outputs reset",
        {req_valid, ovr_flag, irq}, 0);

    // R2 rising edge, N=2
    rmode = 0;
    setcfg(3, 0, 1, 2);
    exp_q.push_back(3); drive(3, 1); settle();
    b0 = bursts; drive(3, 0); settle();
    chk(bursts == b0, "R2 falling ignored", bursts - b0, 0);

    // R3 falling edge, N=4, alternate ready
    rmode = 1;
    setcfg(3, 0, 2, 4);
    b0 = bursts; drive(3, 1); settle();
    chk(bursts == b0, "R3 rising ignored", bursts - b0, 0);
    exp_q.push_back(5); drive(3, 0); settle();

    // R4 both edges, N=0
    rmode = 0;
    setcfg(3, 0, 3, 0);
    b0 = bursts;
    exp_q.push_back(1); drive(3, 1); settle();
    exp_q.push_back(1); drive(3, 0); settle();
    chk(bursts == b0 + 2, "R4 both edges", bursts - b0, 2);

    // R5 mode none
    setcfg(3, 0, 0, 1);
    b0 = bursts; drive(3, 1); drive(3, 0); settle();
    chk(bursts == b0, "R5 no edge mode", bursts - b0, 0);

    // R6 select
    setcfg(3, 0, 1, 1);
    b0 = bursts; drive(5, 1); drive(5, 0); settle();
    chk(bursts == b0, "R6 other line ignored", bursts - b0, 0);
    setcfg(5, 0, 1, 1);
    exp_q.push_back(2); drive(5, 1); drive(5, 0); settle();
    chk(bursts == b0 + 1, "R6 selected line", bursts - b0, 1);

    // R9 count frozen while enabled
    setcfg(5, 0, 1, 1);
    wr(mk(5, 0, 1, 1, 7));
    chk(cfg_rdata[23:19] == 1, "R9 count held", cfg_rdata[23:19], 1);
    exp_q.push_back(2); drive(5, 1); drive(5, 0); settle();

    // R10 / R11 overrun
    rmode = 2;
    setcfg(5, 0, 1, 1);
    exp_q.push_back(2);
    drive(5, 1);
    chk(req_valid == 1, "R8 valid held while stalled", req_valid, 1);
    drive(5, 0); drive(5, 1);
    chk(ovr_flag == 1, "R10 overrun flag", ovr_flag, 1);
    chk(irq == 0, "R11 irq masked", irq, 0);
    wr(mk(5, 1, 1, 1, 1));
    chk(irq == 1, "R11 irq enabled", irq, 1);
    b0 = bursts;
    rmode = 0; settle();
    chk(bursts == b0, "R10 dropped trigger", bursts - b0, 0);
    @(negedge clk); ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    chk(!ovr_flag && !irq, "R11 flag cleared", {ovr_flag, irq}, 0);
    drive(5, 0);

    // R7 abort and disabled
    rmode = 2;
    setcfg(5, 0, 1, 3);
    exp_q.push_back(0);
    drive(5, 1);
    chk(req_valid == 1, "R7 burst running", req_valid, 1);
    wr(mk(5, 0, 0, 1, 3));
    chk(req_valid == 0, "R7 abort", req_valid, 1'b0);
    rmode = 0;
    b0 = bursts; drive(5, 0); drive(5, 1); settle();
    chk(bursts == b0, "R7 disabled no burst", bursts - b0, 0);
    chk(exp_q.size() == 0, "R8 bursts outstanding", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule